// File: doc/BRIEF.md
# Programmable Scan-Pattern Address Generator

This block walks a two-dimensional position (x, y) over a square pixel map, by default 8 by 8 with 1-based coordinates. It does not hold a fixed ordering table. Instead, it interprets a short program that is stored in a small command register file. The commands are: move to the origin; repeat a signed step vector a bounded number of times, with an optional early stop when one coordinate returns to 1; open and close a counted loop; and replay, mirrored, the positions already produced. Each position it reaches is emitted as one address on a valid/ready stream.

Software writes the commands through a plain write port while the block is idle, then pulses `start`. A program of origin, one east step, three passes of (south-west run, south step, north-east run, east step), one more south-west run and a mirror command produces the classic 8x8 zigzag order. The first half, up to and including the main anti-diagonal, is stepped. The remaining 28 positions come from replaying the stored history backwards with each coordinate reflected to (GRID+1-x, GRID+1-y). While the consumer withholds `ready`, the generator stalls and holds the current address. A one-cycle `done` pulse marks the end of the program.

Top module: `scan_addr_gen`

## Requirements
- R1: A command word is 13 bits: opcode in bits [12:10] (0 halt, 1 origin, 2 step, 3 loop open, 4 loop close, 5 mirror, 6 and 7 no-op), signed dx in [9:8], signed dy in [7:6], repeat count in [5:2], and stop select in [1:0] (0 none, 1 stop when x becomes 1, 2 stop when y becomes 1, 3 none). Writes through `cmd_we` take effect only while `busy` is low. A write made while busy leaves the stored program unchanged.
- R2: After reset, `busy`, `done` and `addr_valid` are low. A `start` pulse while idle runs the program from slot 0 with the position, loop and history state cleared. A `start` while busy has no effect.
- R3: The origin command emits the address [1,1] and places the position there.
- R4: A step command adds (dx, dy) and emits the new position, up to `repeat` times. It ends early right after emitting a position that meets its stop condition. A repeat count of 0 emits nothing.
- R5: A step that would carry either coordinate outside 1..GRID ends the command without moving and without emitting.
- R6: The commands between a loop open and its loop close run `repeat` times. A count of 0 or 1 runs them once. Only one loop level exists.
- R7: The mirror command emits the recorded positions newest first, each mapped to (GRID+1-x, GRID+1-y). It skips any recorded position whose x+y is at least GRID+1.
- R8: An emitted address stays on `addr_x`/`addr_y` with `addr_valid` high and unchanged until `addr_ready` is seen high. No address is lost or repeated.
- R9: `done` is high for exactly one cycle, after the final address has been accepted, and `busy` falls with it. When a halt directly follows the last emitting command and `ready` is high, `done` appears in the cycle right after that final transfer. Running past the last slot acts as a halt.
- R10: The standard zigzag program emits all 64 positions of the 8x8 map exactly once, in zigzag order, ending at [8,8].
- R11: With `addr_ready` held high, the addresses of a multi-step run leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write enable (honoured only when idle) |
| cmd_waddr | input | CAW (4) | Command slot to write |
| cmd_wdata | input | 13 | Command word |
| start | input | 1 | Begin the program at slot 0 |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer takes the address |
| addr_x | output | CW (4) | Column, 1..GRID |
| addr_y | output | CW (4) | Row, 1..GRID |

## Verification
The full zigzag program runs three times: with `ready` always high, with `ready` dropping one cycle in three, and with a consumer that takes only every fourth cycle. The stepped half and the mirrored half must be identical across the three runs, and the stalls must not lose, duplicate or shift any address. Short dedicated programs separate the ways a step command can end: its repeat count running out, its stop coordinate being reached, a repeat count of zero, or the map edge. Further short programs set the loop count against a single pass and exercise the skip rule of the mirror on a straight row. A run that has a program write and a second start injected mid-stream, followed by a clean rerun, shows whether those inputs were ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int REP_W = 4;

  typedef enum logic [2:0] {
    OP_HALT    = 3'd0,
    OP_ORIGIN  = 3'd1,
    OP_STEP    = 3'd2,
    OP_LOOP    = 3'd3,
    OP_ENDLOOP = 3'd4,
    OP_MIRROR  = 3'd5,
    OP_NOP6    = 3'd6,
    OP_NOP7    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STOP_NONE = 2'd0,
    STOP_X1   = 2'd1,
    STOP_Y1   = 2'd2,
    STOP_RSV  = 2'd3
  } stop_e;

  typedef struct packed {
    op_e               op;
    logic signed [1:0] dx;
    logic signed [1:0] dy;
    logic [REP_W-1:0]  rep;
    stop_e             stop;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_MRD  = 2'd2,
    ST_MUSE = 2'd3
  } state_e;

endpackage

// File: rtl/scan_cmd_regfile.sv
module scan_cmd_regfile #(
  parameter int DEPTH = 16,
  parameter int W     = 13,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/scan_hist_ram.sv
module scan_hist_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/scan_step_unit.sv
module scan_step_unit
  import scan_pkg::*;
#(
  parameter int GRID = 8,
  parameter int CW   = 4
) (
  input  logic [CW-1:0]     pos_x,
  input  logic [CW-1:0]     pos_y,
  input  logic signed [1:0] dx,
  input  logic signed [1:0] dy,
  input  stop_e             stop,
  output logic [CW-1:0]     nx,
  output logic [CW-1:0]     ny,
  output logic              in_range,
  output logic              stop_hit
);

  logic signed [CW+1:0] sx, sy;

  always_comb begin
    sx = $signed({2'b00, pos_x}) + $signed({{CW{dx[1]}}, dx});
    sy = $signed({2'b00, pos_y}) + $signed({{CW{dy[1]}}, dy});
    in_range = (sx >= 1) && (sx <= GRID) && (sy >= 1) && (sy <= GRID);
    nx = sx[CW-1:0];
    ny = sy[CW-1:0];
    case (stop)
      STOP_X1: stop_hit = (nx == CW'(1));
      STOP_Y1: stop_hit = (ny == CW'(1));
      default: stop_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int GRID      = 8,
  parameter int CMD_DEPTH = 16,
  localparam int CW       = $clog2(GRID + 1),
  localparam int CAW      = $clog2(CMD_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_we,
  input  logic [CAW-1:0]     cmd_waddr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [CW-1:0]      addr_x,
  output logic [CW-1:0]      addr_y
);

  localparam int HIST_DEPTH = GRID * GRID;
  localparam int HAW        = $clog2(HIST_DEPTH);
  localparam int HCW        = $clog2(HIST_DEPTH + 1);
  localparam int PCW        = $clog2(CMD_DEPTH + 1);

  state_e             state;
  logic [PCW-1:0]     pc;
  logic [CW-1:0]      pos_x, pos_y;
  logic [REP_W-1:0]   rep_cnt;
  logic [REP_W-1:0]   loop_cnt;
  logic [PCW-1:0]     loop_pc;
  logic [HCW-1:0]     hist_cnt;
  logic [HAW-1:0]     mir_idx;

  logic               valid_q, done_q;
  logic [CW-1:0]      x_q, y_q;

  logic [CMD_W-1:0]   rf_rdata;
  cmd_t               cur;
  logic               can_emit;

  logic [CW-1:0]      nx, ny;
  logic               in_range, stop_hit;

  logic               fwd_emit;
  logic [CW-1:0]      fwd_x, fwd_y;
  logic               hist_we;
  logic [2*CW-1:0]    hist_rdata;
  logic [CW-1:0]      hx, hy;
  logic               mir_skip;
  logic [CW-1:0]      mx, my;

  // Command storage: writes only when idle
  scan_cmd_regfile #(.DEPTH(CMD_DEPTH), .W(CMD_W)) u_cmds (
    .clk   (clk),
    .we    (cmd_we && (state == ST_IDLE)),
    .waddr (cmd_waddr),
    .wdata (cmd_wdata),
    .raddr (pc[CAW-1:0]),
    .rdata (rf_rdata)
  );

  assign cur = (pc >= PCW'(CMD_DEPTH)) ? '0 : cmd_t'(rf_rdata);
  assign can_emit = !valid_q || addr_ready;

  scan_step_unit #(.GRID(GRID), .CW(CW)) u_step (
    .pos_x    (pos_x),
    .pos_y    (pos_y),
    .dx       (cur.dx),
    .dy       (cur.dy),
    .stop     (cur.stop),
    .nx       (nx),
    .ny       (ny),
    .in_range (in_range),
    .stop_hit (stop_hit)
  );

  // Forward emissions (origin and step) for output and history
  always_comb begin
    fwd_emit = 1'b0;
    fwd_x    = nx;
    fwd_y    = ny;
    if (state == ST_RUN && can_emit) begin
      if (cur.op == OP_ORIGIN) begin
        fwd_emit = 1'b1;
        fwd_x    = CW'(1);
        fwd_y    = CW'(1);
      end else if (cur.op == OP_STEP && cur.rep != '0 && in_range) begin
        fwd_emit = 1'b1;
      end
    end
  end

  assign hist_we = fwd_emit && (hist_cnt < HCW'(HIST_DEPTH));

  scan_hist_ram #(.DEPTH(HIST_DEPTH), .W(2*CW)) u_hist (
    .clk   (clk),
    .we    (hist_we),
    .waddr (hist_cnt[HAW-1:0]),
    .wdata ({fwd_x, fwd_y}),
    .raddr (mir_idx),
    .rdata (hist_rdata)
  );

  assign hx = hist_rdata[2*CW-1:CW];
  assign hy = hist_rdata[CW-1:0];
  assign mir_skip = ({1'b0, hx} + {1'b0, hy}) >= (CW+1)'(GRID + 1);
  assign mx = CW'(GRID + 1) - hx;
  assign my = CW'(GRID + 1) - hy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pc       <= '0;
      pos_x    <= CW'(1);
      pos_y    <= CW'(1);
      rep_cnt  <= '0;
      loop_cnt <= '0;
      loop_pc  <= '0;
      hist_cnt <= '0;
      mir_idx  <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (valid_q && addr_ready) valid_q <= 1'b0;

      if (fwd_emit) begin
        valid_q <= 1'b1;
        x_q     <= fwd_x;
        y_q     <= fwd_y;
        pos_x   <= fwd_x;
        pos_y   <= fwd_y;
        if (hist_cnt < HCW'(HIST_DEPTH)) hist_cnt <= hist_cnt + HCW'(1);
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            pc       <= '0;
            pos_x    <= CW'(1);
            pos_y    <= CW'(1);
            rep_cnt  <= '0;
            loop_cnt <= '0;
            loop_pc  <= '0;
            hist_cnt <= '0;
          end
        end

        ST_RUN: begin
          case (cur.op)
            OP_HALT: begin
              if (can_emit) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end
            end
            OP_ORIGIN: begin
              if (can_emit) pc <= pc + PCW'(1);
            end
            OP_STEP: begin
              if (cur.rep == '0 || !in_range) begin
                pc      <= pc + PCW'(1);
                rep_cnt <= '0;
              end else if (can_emit) begin
                if ((rep_cnt + REP_W'(1)) == cur.rep || stop_hit) begin
                  pc      <= pc + PCW'(1);
                  rep_cnt <= '0;
                end else begin
                  rep_cnt <= rep_cnt + REP_W'(1);
                end
              end
            end
            OP_LOOP: begin
              loop_cnt <= cur.rep;
              loop_pc  <= pc + PCW'(1);
              pc       <= pc + PCW'(1);
            end
            OP_ENDLOOP: begin
              if (loop_cnt > REP_W'(1)) begin
                loop_cnt <= loop_cnt - REP_W'(1);
                pc       <= loop_pc;
              end else begin
                loop_cnt <= '0;
                pc       <= pc + PCW'(1);
              end
            end
            OP_MIRROR: begin
              if (hist_cnt == '0) begin
                pc <= pc + PCW'(1);
              end else begin
                mir_idx <= HAW'(hist_cnt - HCW'(1));
                state   <= ST_MRD;
              end
            end
            default: pc <= pc + PCW'(1);
          endcase
        end

        ST_MRD: state <= ST_MUSE;

        ST_MUSE: begin
          if (mir_skip || can_emit) begin
            if (!mir_skip) begin
              valid_q <= 1'b1;
              x_q     <= mx;
              y_q     <= my;
            end
            if (mir_idx == '0) begin
              pc    <= pc + PCW'(1);
              state <= ST_RUN;
            end else begin
              mir_idx <= mir_idx - HAW'(1);
              state   <= ST_MRD;
            end
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign addr_valid = valid_q;
  assign addr_x     = x_q;
  assign addr_y     = y_q;

endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int GRID = 8,
  parameter int CW   = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [CW-1:0] addr_x,
  input logic [CW-1:0] addr_y
);

  // R8: a stalled address is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_x) && $stable(addr_y));

  // R5: emitted coordinates never leave the map
  a_r5_in_map: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (addr_x >= CW'(1)) && (addr_x <= CW'(GRID)) &&
                   (addr_y >= CW'(1)) && (addr_y <= CW'(GRID)));

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done comes with an idle, drained generator
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !addr_valid);

  // R9: nothing is offered once idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !addr_valid);

  // R2: start while idle begins a run
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);

endmodule

bind scan_addr_gen scan_addr_gen_chk #(.GRID(GRID), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_x     (addr_x),
  .addr_y     (addr_y)
);

// File: tb/scan_addr_gen_bench.sv
`timescale 1ns/1ps
module scan_addr_gen_bench;

  localparam int GRID = 8;
  localparam int CMDS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [3:0]  cmd_waddr = '0;
  logic [12:0] cmd_wdata = '0;
  logic        start = 1'b0;
  logic        addr_ready = 1'b0;
  logic        busy, done, addr_valid;
  logic [3:0]  addr_x, addr_y;

  always #2.5 clk = ~clk;

  scan_addr_gen u_scan_addr_gen (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
    .cmd_wdata(cmd_wdata), .start(start), .busy(busy), .done(done),
    .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_x(addr_x), .addr_y(addr_y)
  );

  int checks = 0;
  int errors = 0;

  int got_x [128];
  int got_y [128];
  int got_c [128];
  int n_got, last_hs, done_at, done_cnt;
  int ex [128];
  int ey [128];
  int n_exp;

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic put(input int idx, input int op, input int dx, input int dy,
                     input int rep, input int stp);
    @(negedge clk);
    cmd_we    = 1'b1;
    cmd_waddr = 4'(idx);
    cmd_wdata = {3'(op), 2'(dx), 2'(dy), 4'(rep), 2'(stp)};
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < CMDS; i++) put(i, 0, 0, 0, 0, 0);
  endtask

  task automatic load_zigzag();
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 2, 1, 0, 1, 0);
    put(2, 3, 0, 0, 3, 0);
    put(3, 2, -1, 1, 8, 1);
    put(4, 2, 0, 1, 1, 0);
    put(5, 2, 1, -1, 8, 2);
    put(6, 2, 1, 0, 1, 0);
    put(7, 4, 0, 0, 0, 0);
    put(8, 2, -1, 1, 8, 1);
    put(9, 5, 0, 0, 0, 0);
  endtask

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      1: return (cyc % 3) != 2;
      2: return (cyc % 4) == 0;
      default: return 1'b1;
    endcase
  endfunction

  // Runs the loaded program, records accepted addresses and the done pulse
  task automatic capture(input int mode, input int inject_at);
    int px, py, stall;
    n_got = 0; last_hs = -1; done_at = -1; done_cnt = 0; stall = 0; px = 0; py = 0;
    @(negedge clk);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      addr_ready = rdy(mode, cyc);
      start      = (cyc == 0) || (cyc == inject_at);
      cmd_we     = (cyc == inject_at);
      cmd_waddr  = '0;
      cmd_wdata  = '0;
      #1;
      if (stall != 0) begin
        chk("R8 hold valid", int'(addr_valid), 1);
        chk("R8 hold x", int'(addr_x), px);
        chk("R8 hold y", int'(addr_y), py);
      end
      stall = addr_valid && !addr_ready;
      px = int'(addr_x); py = int'(addr_y);
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = cyc;
      end
      if (addr_valid && addr_ready && n_got < 128) begin
        got_x[n_got] = int'(addr_x);
        got_y[n_got] = int'(addr_y);
        got_c[n_got] = cyc;
        n_got++;
        last_hs = cyc;
      end
      if (done_at >= 0 && cyc >= done_at + 3) break;
      @(negedge clk);
    end
    start = 1'b0; cmd_we = 1'b0; addr_ready = 1'b0;
  endtask

  task automatic compare(input string req);
    chk({req, " count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk({req, " x"}, got_x[i], ex[i]);
      chk({req, " y"}, got_y[i], ey[i]);
    end
    chk({req, " R9 done once"}, done_cnt, 1);
    chk({req, " R9 done after last"}, int'(done_at > last_hs), 1);
  endtask

  function automatic void build_zigzag();
    int k = 0;
    for (int s = 2; s <= 2 * GRID; s++) begin
      int lo = (s - GRID > 1) ? s - GRID : 1;
      int hi = (s - 1 < GRID) ? s - 1 : GRID;
      if (s % 2 == 1) begin
        for (int x = hi; x >= lo; x--) begin ex[k] = x; ey[k] = s - x; k++; end
      end else begin
        for (int x = lo; x <= hi; x++) begin ex[k] = x; ey[k] = s - x; k++; end
      end
    end
    n_exp = k;
  endfunction

  function automatic void expect_list(input int n, input int xs[16], input int ys[16]);
    for (int i = 0; i < n; i++) begin ex[i] = xs[i]; ey[i] = ys[i]; end
    n_exp = n;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R2 reset valid", int'(addr_valid), 0);
    chk("R2 reset busy", int'(busy), 0);
    chk("R2 reset done", int'(done), 0);
  endtask

  task automatic t_zigzag(input int mode);
    load_zigzag();
    capture(mode, -1);
    build_zigzag();
    compare("R10 zigzag");
    chk("R3 first x", got_x[0], 1);
    chk("R7 last is [8,8]", got_x[63] * 10 + got_y[63], 88);
    if (mode == 0) chk("R9 done cycle", done_at, last_hs + 1);
  endtask

  task automatic t_repeat();
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 2, 1, 0, 3, 0);
    capture(0, -1);
    expect_list(4, '{1,2,3,4,0,0,0,0,0,0,0,0,0,0,0,0}, '{1,1,1,1,0,0,0,0,0,0,0,0,0,0,0,0});
    compare("R4 repeat");
    chk("R11 back-to-back 1", got_c[2] - got_c[1], 1);
    chk("R11 back-to-back 2", got_c[3] - got_c[2], 1);
    chk("R9 done cycle", done_at, last_hs + 1);
  endtask

  task automatic t_stop();
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 2, 1, 0, 2, 0);
    put(2, 2, -1, 1, 8, 1);
    capture(1, -1);
    expect_list(5, '{1,2,3,2,1,0,0,0,0,0,0,0,0,0,0,0}, '{1,1,1,2,3,0,0,0,0,0,0,0,0,0,0,0});
    compare("R4 stop x");
  endtask

  task automatic t_rep0_edge();
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 2, 0, 1, 0, 0);
    put(2, 2, -1, 0, 5, 0);
    put(3, 2, 0, 1, 15, 0);
    capture(0, -1);
    expect_list(8, '{1,1,1,1,1,1,1,1,0,0,0,0,0,0,0,0}, '{1,2,3,4,5,6,7,8,0,0,0,0,0,0,0,0});
    compare("R5 edge and rep0");
  endtask

  task automatic t_loop(input int cnt);
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 3, 0, 0, cnt, 0);
    put(2, 2, 1, 0, 1, 0);
    put(3, 2, 0, 1, 1, 0);
    put(4, 4, 0, 0, 0, 0);
    capture(0, -1);
    if (cnt == 2)
      expect_list(5, '{1,2,2,3,3,0,0,0,0,0,0,0,0,0,0,0}, '{1,1,2,2,3,0,0,0,0,0,0,0,0,0,0,0});
    else
      expect_list(3, '{1,2,2,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{1,1,2,0,0,0,0,0,0,0,0,0,0,0,0,0});
    compare("R6 loop");
  endtask

  task automatic t_mirror();
    clear_prog();
    put(0, 1, 0, 0, 0, 0);
    put(1, 2, 1, 0, 7, 0);
    put(2, 5, 0, 0, 0, 0);
    capture(2, -1);
    for (int i = 0; i < 8; i++) begin ex[i] = i + 1; ey[i] = 1; end
    for (int j = 0; j < 7; j++) begin ex[8 + j] = 2 + j; ey[8 + j] = 8; end
    n_exp = 15;
    compare("R7 mirror skip");
  endtask

  task automatic t_halt_only();
    clear_prog();
    capture(0, -1);
    chk("R9 empty count", n_got, 0);
    chk("R9 empty done", done_cnt, 1);
  endtask

  task automatic t_busy_ignore();
    load_zigzag();
    capture(0, 20);
    build_zigzag();
    compare("R2 start while busy");
    capture(0, -1);
    compare("R1 write while busy");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zigzag(0);
    t_zigzag(1);
    t_zigzag(2);
    t_repeat();
    t_stop();
    t_rep0_edge();
    t_loop(2);
    t_loop(0);
    t_mirror();
    t_halt_only();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule